// File: doc/BRIEF.md
# Interleaved Line Memory Server

This block models the memory level below a cache and serves whole four-word lines to it. Each transaction counts the bus cycles taken by a fixed timing model. Sending the address costs one cycle. Each memory access the block starts costs a parameterised number of cycles, 15 by default. Each transfer on the response bus costs one cycle. One parameter selects the physical organisation, and the organisation alone decides how many bus cycles a line costs:

- **Narrow:** one word-wide store, read four times in a row.
- **Wide:** a store and bus two or four words wide.
- **Banked:** four word-wide banks, all accessed at once and then drained one word per cycle.

Every organisation stores word w of a line in bank w, selected by the low two bits of the word address.

A requester presents a line number, a read/write flag and, for writes, a full line of data. The block takes the request only while it is idle. For a read, it drives the response bus during the transfer cycles only. A one-cycle completion pulse marks the final cycle of every transaction. After each transaction, a counter output holds the number of bus cycles that transaction used, so the miss penalty can be compared against the arithmetic of the chosen organisation: 65, 33, 17 or 20 cycles with the default access time.

Top module: `lsrv_line_server`

## Requirements
- R1: Out of reset the block is ready, the response valid and completion outputs are low, and the penalty counter reads zero.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is low from the cycle after that edge through the completion cycle, and high again in the cycle after completion.
- R3: Narrow organisation, counting the first cycle after acceptance as cycle 1: one word per beat, beats in cycles 17, 33, 49 and 65, completion in cycle 65.
- R4: Wide organisation with W words per beat: beat g arrives in cycle 1+16*(g+1), and the line completes in cycle 33 (W=2) or 17 (W=4).
- R5: Banked organisation: one word per beat in cycles 17, 18, 19 and 20, completion in cycle 20.
- R6: rsp_valid is high only in the transfer cycles of a read and never during a write. A read gives exactly 4/W beats, with the last beat in the completion cycle.
- R7: done is high for exactly one cycle per transaction, in its final cycle (read or write).
- R8: From the cycle after completion until the next completion, last_penalty holds the cycle count of the finished transaction (65, 33, 17 or 20 by default).
- R9: Beats carry the words of a line in ascending order. Within a beat, the lowest-numbered word sits in rsp_data bits [DATA_W-1:0]. Word w of req_wdata sits in bits [w*DATA_W +: DATA_W].
- R10: A write stores the whole line. A later read of that line returns the last data written to it.
- R11: A request presented while the block is busy is not taken and changes no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = store a line, 0 = fetch a line |
| req_line | input | LADDR_W | Line number |
| req_wdata | input | 4*DATA_W | Line to store, word w at bits [w*DATA_W +: DATA_W] |
| rsp_valid | output | 1 | Read beat present on rsp_data |
| rsp_data | output | BUS_W*DATA_W | Beat data; BUS_W is WIDE_WORDS for the wide organisation, otherwise 1 |
| done | output | 1 | Final cycle of the transaction |
| last_penalty | output | CNT_W | Bus cycles used by the last finished transaction |

## Verification
The assertions check the following on every cycle:
- the handshake: no second acceptance while busy, and ready is back one cycle after completion;
- that completion is a single-cycle pulse;
- that response beats never appear during a write;
- the beat count of each read;
- that the penalty counter stays stable between completions and matches the organisation's total.

The exact cycle of each beat, the word order, the data returned after writes and the ignored busy-time requests can only be shown by the bench's scenarios. The bench runs all four organisations side by side over a sweep of every line, with expected data and beat cycles computed arithmetically.

// File: rtl/lsrv_pkg.sv
package lsrv_pkg;
  typedef enum logic [1:0] {
    ORG_NARROW = 2'd0,
    ORG_WIDE   = 2'd1,
    ORG_BANKED = 2'd2
  } org_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACC  = 2'd2,
    ST_XFER = 2'd3
  } st_e;

  localparam int LINE_WORDS = 4;
endpackage

// File: rtl/lsrv_bank.sv
module lsrv_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/lsrv_seq.sv
module lsrv_seq #(
  parameter int GROUPS  = 1,
  parameter int BEATS   = 4,
  parameter int ACC_CYC = 15,
  parameter int CNT_W   = 5,
  parameter int BEAT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              idle,
  output logic              xfer,
  output logic              last,
  output logic [BEAT_W-1:0] beat,
  output logic [CNT_W-1:0]  cyc
);
  import lsrv_pkg::*;

  localparam int ACC_W = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
  localparam int BIN_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  st_e              st;
  logic [ACC_W-1:0] acc_cnt;
  logic [BIN_W-1:0] bin;
  logic [GRP_W-1:0] grp;
  logic             grp_end;

  assign idle    = (st == ST_IDLE);
  assign xfer    = (st == ST_XFER);
  assign grp_end = (bin == BIN_W'(BEATS - 1));
  assign last    = xfer && grp_end && (grp == GRP_W'(GROUPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      acc_cnt <= '0;
      bin     <= '0;
      grp     <= '0;
      beat    <= '0;
      cyc     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st   <= ST_ADDR;
          cyc  <= CNT_W'(1);
          beat <= '0;
          grp  <= '0;
        end
        ST_ADDR: begin
          st      <= ST_ACC;
          acc_cnt <= '0;
          cyc     <= cyc + 1'b1;
        end
        ST_ACC: begin
          cyc <= cyc + 1'b1;
          if (acc_cnt == ACC_W'(ACC_CYC - 1)) begin
            st  <= ST_XFER;
            bin <= '0;
          end else begin
            acc_cnt <= acc_cnt + 1'b1;
          end
        end
        ST_XFER: begin
          beat <= beat + 1'b1;
          if (grp_end) begin
            if (last) begin
              st <= ST_IDLE;
            end else begin
              st      <= ST_ACC;
              acc_cnt <= '0;
              grp     <= grp + 1'b1;
              cyc     <= cyc + 1'b1;
            end
          end else begin
            bin <= bin + 1'b1;
            cyc <= cyc + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsrv_line_server.sv
module lsrv_line_server #(
  parameter lsrv_pkg::org_e ORG = lsrv_pkg::ORG_BANKED,
  parameter int WIDE_WORDS = 2,
  parameter int DATA_W     = 16,
  parameter int LADDR_W    = 4,
  parameter int ACC_CYC    = 15,
  localparam int LW        = lsrv_pkg::LINE_WORDS,
  localparam int BUS_W     = (ORG == lsrv_pkg::ORG_WIDE) ? WIDE_WORDS : 1,
  localparam int GRP_BEATS = (ORG == lsrv_pkg::ORG_BANKED) ? LW : 1,
  localparam int GROUPS    = LW / (BUS_W * GRP_BEATS),
  localparam int NBEATS    = GROUPS * GRP_BEATS,
  localparam int PENALTY   = 1 + GROUPS * (ACC_CYC + GRP_BEATS),
  localparam int CNT_W     = $clog2(PENALTY + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [LADDR_W-1:0]      req_line,
  input  logic [LW*DATA_W-1:0]    req_wdata,
  output logic                    rsp_valid,
  output logic [BUS_W*DATA_W-1:0] rsp_data,
  output logic                    done,
  output logic [CNT_W-1:0]        last_penalty
);
  localparam int BEAT_W = $clog2(LW);

  logic                 accept;
  logic                 idle, xfer, last;
  logic [BEAT_W-1:0]    beat;
  logic [CNT_W-1:0]     cyc;
  logic [LADDR_W-1:0]   cur_line;
  logic                 cur_write;
  logic [LW*DATA_W-1:0] wbuf;
  logic [DATA_W-1:0]    q [LW];

  assign req_ready = idle;
  assign accept    = req_valid && idle;
  assign rsp_valid = xfer && !cur_write;
  assign done      = last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_line     <= '0;
      cur_write    <= 1'b0;
      wbuf         <= '0;
      last_penalty <= '0;
    end else begin
      if (accept) begin
        cur_line  <= req_line;
        cur_write <= req_write;
        wbuf      <= req_wdata;
      end
      if (last) last_penalty <= cyc;
    end
  end

  lsrv_seq #(
    .GROUPS (GROUPS),
    .BEATS  (GRP_BEATS),
    .ACC_CYC(ACC_CYC),
    .CNT_W  (CNT_W),
    .BEAT_W (BEAT_W)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(accept),
    .idle (idle),
    .xfer (xfer),
    .last (last),
    .beat (beat),
    .cyc  (cyc)
  );

  for (genvar w = 0; w < LW; w++) begin : g_bank
    lsrv_bank #(.DATA_W(DATA_W), .ADDR_W(LADDR_W)) u_bank (
      .clk  (clk),
      .we   (last && cur_write),
      .addr (cur_line),
      .wdata(wbuf[w*DATA_W +: DATA_W]),
      .rdata(q[w])
    );
  end

  always_comb begin
    rsp_data = '0;
    for (int i = 0; i < BUS_W; i++) begin
      for (int w = 0; w < LW; w++) begin
        if (int'(beat) * BUS_W + i == w) rsp_data[i*DATA_W +: DATA_W] = q[w];
      end
    end
  end
endmodule

// File: rtl/lsrv_chk.sv
module lsrv_chk #(
  parameter int PEN = 20,
  parameter int CW  = 5,
  parameter int NB  = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          done,
  input logic [CW-1:0] last_penalty,
  input logic          cur_write
);
  logic [3:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= '0;
    else if (req_valid && req_ready) bcnt <= '0;
    else if (rsp_valid) bcnt <= bcnt + 1'b1;
  end

  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready); // R2
  AST_VALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R6
  AST_NO_BEAT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cur_write); // R6
  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (rst)
    (done && !cur_write) |-> (rsp_valid && (bcnt + 4'd1 == 4'(NB)))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_PENALTY_VALUE: assert property (@(posedge clk) disable iff (rst)
    done |=> (last_penalty == CW'(PEN))); // R8
  AST_PENALTY_STABLE: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(last_penalty)); // R8
endmodule

bind lsrv_line_server lsrv_chk #(.PEN(PENALTY), .CW(CNT_W), .NB(NBEATS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .done        (done),
  .last_penalty(last_penalty),
  .cur_write   (cur_write)
);

// File: tb/tb_lsrv_line_server.sv
`timescale 1ns/1ps
module tb_lane #(
  parameter lsrv_pkg::org_e ORG = lsrv_pkg::ORG_BANKED,
  parameter int WIDE_WORDS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_line,
  input  logic [63:0] req_wdata,
  output logic        ready,
  output int          n_chk,
  output int          n_fail
);
  localparam int BW = (ORG == lsrv_pkg::ORG_WIDE) ? WIDE_WORDS : 1;
  localparam int T  = (ORG == lsrv_pkg::ORG_BANKED) ? 4 : 1;
  localparam int G  = 4 / (BW * T);
  localparam int NB = 4 / BW;
  localparam int P  = 1 + G * (15 + T);
  localparam int PW = $clog2(P + 1);

  logic            rsp_valid, done;
  logic [BW*16-1:0] rsp_data;
  logic [PW-1:0]   lp;

  lsrv_line_server #(.ORG(ORG), .WIDE_WORDS(WIDE_WORDS)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready),
    .req_write(req_write), .req_line(req_line), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .last_penalty(lp)
  );

  int c = 0;
  int f = 0;
  assign n_chk  = c;
  assign n_fail = f;

  string ttag;
  initial ttag = (ORG == lsrv_pkg::ORG_NARROW) ? "R3" : (ORG == lsrv_pkg::ORG_WIDE) ? "R4" : "R5";

  logic [15:0] refm [16][4];
  bit   active, post, wr, seen;
  int   cyc, line;

  task automatic note(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
    c++;
    if (!ok) begin
      f++;
      $display("FAIL %s org=%0d bus=%0d: %s actual=%0h expected=%0h",
               tag, ORG, BW, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      active = 0; post = 0; seen = 0;
    end else begin
      if (!seen) begin
        seen = 1;
        note(ready == 1'b1, "R1", "ready after reset", ready, 1);
        note(rsp_valid == 1'b0 && done == 1'b0, "R1", "valid/done after reset",
             {rsp_valid, done}, 0);
        note(lp == 0, "R1", "penalty after reset", lp, 0);
      end
      if (post) begin
        post = 0;
        note(lp == PW'(P), "R8", "last_penalty", lp, P);
        note(ready == 1'b1, "R2", "ready after done", ready, 1);
      end
      if (active) begin
        bit isbeat;
        int k;
        logic [BW*16-1:0] exp;
        cyc++;
        isbeat = 0; k = 0;
        for (int j = 0; j < NB; j++)
          if (cyc == 1 + (j / T) * (15 + T) + 16 + (j % T)) begin isbeat = 1; k = j; end
        note(rsp_valid == (isbeat && !wr), {ttag, " R6"}, "rsp_valid timing",
             rsp_valid, isbeat && !wr);
        note(done == (cyc == P), {ttag, " R7"}, "done timing", done, cyc == P);
        note(ready == 1'b0, "R2", "ready while busy", ready, 0);
        if (isbeat && !wr) begin
          for (int i = 0; i < BW; i++) exp[i*16 +: 16] = refm[line][k*BW + i];
          // word order and stored data; includes lines probed after busy-time requests
          note(rsp_data == exp, "R9 R10 R11", "beat data", rsp_data, exp);
        end
        if (cyc == P) begin active = 0; post = 1; end
      end
      if (!active && req_valid && ready) begin
        active = 1; cyc = 0; wr = req_write; line = int'(req_line);
        if (wr) for (int w = 0; w < 4; w++) refm[line][w] = req_wdata[w*16 +: 16];
      end
    end
  end
endmodule

module tb_lsrv_line_server;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_line = '0;
  logic [63:0] req_wdata = '0;
  logic [3:0]  rdy;
  int          chk [4];
  int          fl [4];

  always #4 clk = ~clk;

  tb_lane #(.ORG(lsrv_pkg::ORG_NARROW)) u_nar (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
    .req_wdata(req_wdata), .ready(rdy[0]), .n_chk(chk[0]), .n_fail(fl[0]));
  tb_lane #(.ORG(lsrv_pkg::ORG_WIDE), .WIDE_WORDS(2)) u_w2 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
    .req_wdata(req_wdata), .ready(rdy[1]), .n_chk(chk[1]), .n_fail(fl[1]));
  tb_lane #(.ORG(lsrv_pkg::ORG_WIDE), .WIDE_WORDS(4)) u_w4 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
    .req_wdata(req_wdata), .ready(rdy[2]), .n_chk(chk[2]), .n_fail(fl[2]));
  tb_lane #(.ORG(lsrv_pkg::ORG_BANKED)) u_bnk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
    .req_wdata(req_wdata), .ready(rdy[3]), .n_chk(chk[3]), .n_fail(fl[3]));

  function automatic logic [63:0] pat(input int ln, input int seed);
    logic [63:0] v;
    for (int w = 0; w < 4; w++) v[w*16 +: 16] = 16'(ln * 4099 + w * 257 + seed * 31 + 7);
    return v;
  endfunction

  task automatic issue(input bit wr, input int ln, input logic [63:0] d, input int hold);
    do @(negedge clk); while (rdy != 4'hF);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_line = 4'(ln); req_wdata = d;
    @(posedge clk); #1;
    if (hold > 0) begin
      // R11: a store to the same line stays presented while every lane is busy
      req_write = 1'b1; req_wdata = 64'hDEAD_BEEF_0BAD_F00D;
      repeat (hold) @(posedge clk);
      #1;
    end
    req_valid = 1'b0;
  endtask

  bit timeout = 0;
  int total, failed;

  initial begin
    fork
      begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        for (int l = 0; l < 16; l++) issue(1, l, pat(l, 1), 0);
        for (int l = 0; l < 16; l++) issue(0, l, '0, 0);
        issue(0, 3, '0, 10);
        issue(0, 3, '0, 0);
        issue(1, 5, pat(5, 2), 0);
        issue(0, 5, '0, 0);
        for (int l = 15; l >= 0; l--) issue(1, l, pat(l, 3), 0);
        for (int l = 0; l < 16; l++) issue(0, l, '0, 0);
        do @(negedge clk); while (rdy != 4'hF);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (200000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    total = 0; failed = 0;
    for (int i = 0; i < 4; i++) begin total += chk[i]; failed += fl[i]; end
    if (timeout) begin
      total++; failed++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule